// File: doc/BRIEF.md
# Single-Cycle Load/Store/Branch Datapath

This block is the execution core of a small 32-bit processor that completes one instruction per clock. It implements four instructions: a register-to-register add, a word load, a word store and a branch taken when two registers are equal. A program counter, a 32-by-32 register file with two combinational read ports and one clocked write port, a sign extender, a shared adder/subtractor and the next-PC logic are all inside the block.

Instruction and data storage live outside it. The block drives the current fetch address on `pc_o` and takes the instruction on `instr_i` in the same cycle. For a load, it presents the effective address and takes the load word on `dmem_rdata_i` in the same cycle. For a store, it raises a write strobe together with the address and data, and the memory captures them on the next rising edge. The register write-back port is also visible at the boundary, so the surrounding memory model or a trace monitor can follow every architectural update.

Top module: `sc_datapath`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), `pc_o` is 0 and every register holds 0. After release, the first fetch is from address 0.
- R2: When no branch is taken, `pc_o` advances by 4 on each rising clock edge.
- R3: Field positions: opcode is bits 31:26, rs is bits 25:21, rt is bits 20:16, rd is bits 15:11, funct is bits 5:0 and the immediate is bits 15:0. Opcode 000000 with funct 100000 writes rs+rt into rd, and `rf_we_o`, `rf_waddr_o` and `rf_wdata_o` show that write in the same cycle.
- R4: Opcode 100011 (load) drives `dmem_addr_o` with rs plus the sign-extended immediate and writes `dmem_rdata_i` into rt.
- R5: Opcode 101011 (store) raises `dmem_we_o`, drives `dmem_addr_o` with rs plus the sign-extended immediate and drives `dmem_wdata_o` with rt. It writes no register.
- R6: Opcode 000100 compares rs and rt by subtraction. When the result is zero, `branch_taken_o` is high and the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the next PC is PC+4.
- R7: Register 0 always reads as 0. A write aimed at it is dropped, and `rf_we_o` stays low for it.
- R8: Any other opcode, or opcode 000000 with a funct other than 100000, writes neither a register nor memory and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction fetched from `pc_o` |
| dmem_rdata_i | input | 32 | Load word for the address on `dmem_addr_o` |
| pc_o | output | 32 | Current program counter / fetch address |
| dmem_we_o | output | 1 | Store strobe |
| dmem_addr_o | output | 32 | Effective byte address for load/store |
| dmem_wdata_o | output | 32 | Store data (rt) |
| rf_we_o | output | 1 | Register write commits at the next edge |
| rf_waddr_o | output | 5 | Destination register index |
| rf_wdata_o | output | 32 | Value written to the destination |
| branch_taken_o | output | 1 | Current branch is taken |

## Verification
A wrong next-PC value shows on `pc_o` one cycle after the faulty instruction, so each program step checks the fetch address in the cycle after it. A corrupted or missing register write is not visible when it happens. It shows up only when that register is next read as a store's data, a load/store base or a branch operand. The stimulus therefore reads back every written register within a few instructions: stores expose register 0 and the value left behind by a rejected funct, and a reset in mid-program is followed at once by a store that exposes the cleared file.

// File: rtl/dp_pkg.sv
`timescale 1ns/1ps
package dp_pkg;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned NREGS  = 1 << REG_AW;
  localparam int unsigned IMM_W  = 16;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] FN_ADD   = 6'b100000;

  typedef enum logic [0:0] {ALU_ADD = 1'b0, ALU_SUB = 1'b1} alu_op_e;

  typedef struct packed {
    logic [5:0]        opcode;
    logic [REG_AW-1:0] rs;
    logic [REG_AW-1:0] rt;
    logic [REG_AW-1:0] rd;
    logic [4:0]        shamt;
    logic [5:0]        funct;
  } instr_fields_t;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rt;
    logic    load;
    logic    store;
    logic    branch;
    logic    use_imm;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/dp_decode.sv
`timescale 1ns/1ps
module dp_decode
  import dp_pkg::*;
(
  input  logic [31:0] instr_i,
  output ctrl_t       ctrl_o
);
  instr_fields_t f;
  assign f = instr_fields_t'(instr_i);

  always_comb begin
    ctrl_o = '{reg_we: 1'b0, dst_rt: 1'b0, load: 1'b0, store: 1'b0,
               branch: 1'b0, use_imm: 1'b0, alu_op: ALU_ADD};
    unique case (f.opcode)
      OP_RTYPE: if (f.funct == FN_ADD) ctrl_o.reg_we = 1'b1;
      OP_LW: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.dst_rt  = 1'b1;
        ctrl_o.load    = 1'b1;
        ctrl_o.use_imm = 1'b1;
      end
      OP_SW: begin
        ctrl_o.store   = 1'b1;
        ctrl_o.use_imm = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dp_regfile.sv
`timescale 1ns/1ps
module dp_regfile #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i
);
  localparam int unsigned N = 1 << AW;

  logic [N-1:0][DW-1:0] regs_q;

  // entry 0 is never written, so it stays at its reset value of zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (we_i && (wa_i != '0)) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign rdata_a_o = regs_q[ra_i];
  assign rdata_b_o = regs_q[rb_i];
endmodule

// File: rtl/dp_alu.sv
`timescale 1ns/1ps
module dp_alu
  import dp_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_op_e       op_i,
  output logic [DW-1:0] y_o,
  output logic          zero_o
);
  logic [DW-1:0] b_eff;
  logic          cin;

  // one adder; subtraction through inverted operand and carry-in
  assign b_eff  = (op_i == ALU_SUB) ? ~b_i : b_i;
  assign cin    = (op_i == ALU_SUB);
  assign y_o    = a_i + b_eff + {{(DW-1){1'b0}}, cin};
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/dp_pc.sv
`timescale 1ns/1ps
module dp_pc #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          taken_i,
  input  logic [DW-1:0] offset_i,
  output logic [DW-1:0] pc_o
);
  localparam logic [DW-1:0] STEP = DW'(4);

  logic [DW-1:0] pc_q, pc_inc, pc_next;

  assign pc_inc  = pc_q + STEP;
  assign pc_next = taken_i ? pc_inc + {offset_i[DW-3:0], 2'b00} : pc_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/sc_datapath.sv
`timescale 1ns/1ps
module sc_datapath
  import dp_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       instr_i,
  input  logic [DW-1:0]     dmem_rdata_i,
  output logic [DW-1:0]     pc_o,
  output logic              dmem_we_o,
  output logic [DW-1:0]     dmem_addr_o,
  output logic [DW-1:0]     dmem_wdata_o,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [DW-1:0]     rf_wdata_o,
  output logic              branch_taken_o
);
  instr_fields_t     f;
  ctrl_t             ctrl;
  logic [DW-1:0]     rs_val, rt_val, imm_ext, alu_b, alu_y;
  logic              alu_zero;
  logic [REG_AW-1:0] waddr;

  assign f       = instr_fields_t'(instr_i);
  assign imm_ext = {{(DW-IMM_W){instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};

  dp_decode u_dec (
    .instr_i (instr_i),
    .ctrl_o  (ctrl)
  );

  dp_regfile #(.DW(DW), .AW(REG_AW)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_i      (f.rs),
    .rb_i      (f.rt),
    .rdata_a_o (rs_val),
    .rdata_b_o (rt_val),
    .we_i      (rf_we_o),
    .wa_i      (waddr),
    .wd_i      (rf_wdata_o)
  );

  assign alu_b = ctrl.use_imm ? imm_ext : rt_val;

  dp_alu #(.DW(DW)) u_alu (
    .a_i    (rs_val),
    .b_i    (alu_b),
    .op_i   (ctrl.alu_op),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  assign branch_taken_o = ctrl.branch & alu_zero;

  dp_pc #(.DW(DW)) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .taken_i  (branch_taken_o),
    .offset_i (imm_ext),
    .pc_o     (pc_o)
  );

  assign waddr        = ctrl.dst_rt ? f.rt : f.rd;
  assign rf_waddr_o   = waddr;
  assign rf_we_o      = ctrl.reg_we && (waddr != '0);
  assign rf_wdata_o   = ctrl.load ? dmem_rdata_i : alu_y;
  assign dmem_we_o    = ctrl.store;
  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rt_val;
endmodule

// File: rtl/sc_datapath_chk.sv
`timescale 1ns/1ps
module sc_datapath_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [31:0]   instr_i,
  input logic [DW-1:0] pc_o,
  input logic          dmem_we_o,
  input logic          rf_we_o,
  input logic [4:0]    rf_waddr_o,
  input logic          branch_taken_o
);
  logic [DW-1:0] off_ext;
  assign off_ext = {{(DW-16){instr_i[15]}}, instr_i[15:0]};

  p_pc_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> pc_o == '0);

  p_pc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !branch_taken_o |=> pc_o == $past(pc_o) + DW'(4));

  p_branch_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_taken_o |=> pc_o == $past(pc_o) + DW'(4) + {$past(off_ext[DW-3:0]), 2'b00});

  p_taken_only_beq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_taken_o |-> instr_i[31:26] == 6'b000100);

  p_store_only_sw_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> (instr_i[31:26] == 6'b101011) && !rf_we_o);

  p_no_zero_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> rf_waddr_o != 5'd0);

  p_other_nop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[31:26] != 6'b000000 && instr_i[31:26] != 6'b100011) |-> !rf_we_o);
endmodule

bind sc_datapath sc_datapath_chk #(.DW(DW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .instr_i        (instr_i),
  .pc_o           (pc_o),
  .dmem_we_o      (dmem_we_o),
  .rf_we_o        (rf_we_o),
  .rf_waddr_o     (rf_waddr_o),
  .branch_taken_o (branch_taken_o)
);

// File: tb/sc_datapath_test.sv
`timescale 1ns/1ps
module sc_datapath_test;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [31:0] instr_i, dmem_rdata_i;
  logic [31:0] pc_o, dmem_addr_o, dmem_wdata_o, rf_wdata_o;
  logic        dmem_we_o, rf_we_o, branch_taken_o;
  logic [4:0]  rf_waddr_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sc_datapath uut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .instr_i        (instr_i),
    .dmem_rdata_i   (dmem_rdata_i),
    .pc_o           (pc_o),
    .dmem_we_o      (dmem_we_o),
    .dmem_addr_o    (dmem_addr_o),
    .dmem_wdata_o   (dmem_wdata_o),
    .rf_we_o        (rf_we_o),
    .rf_waddr_o     (rf_waddr_o),
    .rf_wdata_o     (rf_wdata_o),
    .branch_taken_o (branch_taken_o)
  );

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] rdata;
    logic [31:0] pc;
    logic        mem;
    logic        mwe;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        rwe;
    logic [4:0]  waddr;
    logic [31:0] rwd;
    logic        taken;
  } vec_t;

  localparam int NV = 21;
  // instr, load data, expected pc, mem op, store, addr, store data, reg write, dest, wb data, taken
  localparam vec_t VEC [NV] = '{
    '{32'h8C020064, 32'h11111111, 32'h00, 1'b1, 1'b0, 32'h00000064, 32'h0, 1'b1, 5'd2,  32'h11111111, 1'b0},
    '{32'h8C43FFFC, 32'h22222222, 32'h04, 1'b1, 1'b0, 32'h1111110D, 32'h0, 1'b1, 5'd3,  32'h22222222, 1'b0},
    '{32'h00430820, 32'h0,        32'h08, 1'b0, 1'b0, 32'h0,        32'h0, 1'b1, 5'd1,  32'h33333333, 1'b0},
    '{32'h8C410064, 32'hCAFEF00D, 32'h0C, 1'b1, 1'b0, 32'h11111175, 32'h0, 1'b1, 5'd1,  32'hCAFEF00D, 1'b0},
    '{32'hAC010008, 32'h0,        32'h10, 1'b1, 1'b1, 32'h00000008, 32'hCAFEF00D, 1'b0, 5'd0, 32'h0, 1'b0},
    '{32'h00430020, 32'h0,        32'h14, 1'b0, 1'b0, 32'h0,        32'h0, 1'b0, 5'd0,  32'h0,        1'b0},
    '{32'hAC00000C, 32'h0,        32'h18, 1'b1, 1'b1, 32'h0000000C, 32'h0, 1'b0, 5'd0,  32'h0,        1'b0},
    '{32'h10430005, 32'h0,        32'h1C, 1'b0, 1'b0, 32'h0,        32'h0, 1'b0, 5'd0,  32'h0,        1'b0},
    '{32'h00405020, 32'h0,        32'h20, 1'b0, 1'b0, 32'h0,        32'h0, 1'b1, 5'd10, 32'h11111111, 1'b0},
    '{32'h00406020, 32'h0,        32'h24, 1'b0, 1'b0, 32'h0,        32'h0, 1'b1, 5'd12, 32'h11111111, 1'b0},
    '{32'h114C0003, 32'h0,        32'h28, 1'b0, 1'b0, 32'h0,        32'h0, 1'b0, 5'd0,  32'h0,        1'b1},
    '{32'h114CFFFC, 32'h0,        32'h38, 1'b0, 1'b0, 32'h0,        32'h0, 1'b0, 5'd0,  32'h0,        1'b1},
    '{32'h3C01FFFF, 32'h0,        32'h2C, 1'b0, 1'b0, 32'h0,        32'h0, 1'b0, 5'd0,  32'h0,        1'b0},
    '{32'h00430822, 32'h0,        32'h30, 1'b0, 1'b0, 32'h0,        32'h0, 1'b0, 5'd0,  32'h0,        1'b0},
    '{32'hAC010000, 32'h0,        32'h34, 1'b1, 1'b1, 32'h00000000, 32'hCAFEF00D, 1'b0, 5'd0, 32'h0, 1'b0},
    '{32'h10220001, 32'h0,        32'h38, 1'b0, 1'b0, 32'h0,        32'h0, 1'b0, 5'd0,  32'h0,        1'b0},
    '{32'h8C000004, 32'hFFFFFFFF, 32'h3C, 1'b1, 1'b0, 32'h00000004, 32'h0, 1'b0, 5'd0,  32'h0,        1'b0},
    '{32'hAC000010, 32'h0,        32'h40, 1'b1, 1'b1, 32'h00000010, 32'h0, 1'b0, 5'd0,  32'h0,        1'b0},
    '{32'hAD8A0000, 32'h0,        32'h44, 1'b1, 1'b1, 32'h11111111, 32'h11111111, 1'b0, 5'd0, 32'h0, 1'b0},
    '{32'h114CFFF0, 32'h0,        32'h48, 1'b0, 1'b0, 32'h0,        32'h0, 1'b0, 5'd0,  32'h0,        1'b1},
    '{32'h00000000, 32'h0,        32'h0C, 1'b0, 1'b0, 32'h0,        32'h0, 1'b0, 5'd0,  32'h0,        1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni       = 1'b0;
    instr_i      = 32'h0;
    dmem_rdata_i = 32'h0;
    repeat (2) @(negedge clk);
    #2 check(pc_o == 32'h0, "R1 pc in reset", pc_o, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      instr_i      = VEC[i].instr;
      dmem_rdata_i = VEC[i].rdata;
      #2;
      check(pc_o == VEC[i].pc, $sformatf("R2/R6 pc step %0d", i), pc_o, VEC[i].pc);
      check(dmem_we_o == VEC[i].mwe, $sformatf("R5/R8 store strobe step %0d", i),
            32'(dmem_we_o), 32'(VEC[i].mwe));
      check(rf_we_o == VEC[i].rwe, $sformatf("R3/R7/R8 reg write step %0d", i),
            32'(rf_we_o), 32'(VEC[i].rwe));
      check(branch_taken_o == VEC[i].taken, $sformatf("R6 taken step %0d", i),
            32'(branch_taken_o), 32'(VEC[i].taken));
      if (VEC[i].mem)
        check(dmem_addr_o == VEC[i].addr, $sformatf("R4/R5 address step %0d", i),
              dmem_addr_o, VEC[i].addr);
      if (VEC[i].mwe)
        check(dmem_wdata_o == VEC[i].wdata, $sformatf("R5/R7 store data step %0d", i),
              dmem_wdata_o, VEC[i].wdata);
      if (VEC[i].rwe) begin
        check(rf_waddr_o == VEC[i].waddr, $sformatf("R3/R4 dest step %0d", i),
              32'(rf_waddr_o), 32'(VEC[i].waddr));
        check(rf_wdata_o == VEC[i].rwd, $sformatf("R3/R4 wb data step %0d", i),
              rf_wdata_o, VEC[i].rwd);
      end
      @(negedge clk);
    end

    // R1: reset in mid-program clears PC at once and empties the register file
    instr_i = 32'h0;
    rst_ni  = 1'b0;
    #2 check(pc_o == 32'h0, "R1 async pc clear", pc_o, 32'h0);
    @(negedge clk);
    rst_ni  = 1'b1;
    instr_i = 32'hAC010000;
    #2;
    check(pc_o == 32'h0, "R1 fetch from zero", pc_o, 32'h0);
    check(dmem_wdata_o == 32'h0, "R1 register cleared", dmem_wdata_o, 32'h0);
    @(negedge clk);
    instr_i = 32'h0;
    #2 check(pc_o == 32'h4, "R2 first step after reset", pc_o, 32'h4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule